// File: doc/BRIEF.md
# Single-Vector Interrupt Flag Controller

This block gathers four interrupt sources of a small processor core into one request line and one fixed handler address. The sources are a timer overflow pulse, an asynchronous external pin with a selectable active edge, a port-change pulse and a nonvolatile-write-complete pulse. Each source owns a sticky flag that records the event whatever the masks say. It also owns an enable bit. A global enable gates the whole request. Only software clears a flag. The handler reads the flags to find out which source called, because every source shares the same vector.

The core talks to the block through three paths. The first is an 8-bit register port with a one-bit register select: software reads the flags, writes the enables and clears the flags through it. The second is a take strobe, which the core asserts at an instruction boundary when it accepts the request. The block then drops the global enable and marks a handler as running. The third is a return strobe, which brings the global enable back and ends the handler. Pushing and popping the program counter, and saving any context, stay in the core.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset all four flags, all four enables and the global enable are 0, both registers read 0x00, and `irq_req` is 0.
- R2: A one-cycle pulse on `tmr_ovf`, `port_chg` or `nvm_done` sets its flag at the next clock edge, even when its enable and the global enable are 0. The flag positions are: register 0 bit 2 for the timer, register 0 bit 0 for the port change, and register 1 bit 0 for the nonvolatile event.
- R3: The external flag (register 0 bit 1) is set by a rising edge of `ext_pin` when `ext_rise_sel` is 1, and by a falling edge when it is 0. The opposite edge leaves it unchanged. The flag becomes visible three clock edges after the pin changes.
- R4: The block never clears a flag on its own, including on take and on return. A register write that carries 0 in a flag's bit position clears that flag.
- R5: If a source event and a software clear reach the same flag in the same cycle, the flag ends up set.
- R6: `irq_req` is 1 exactly when the global enable is 1, no handler is running, and at least one flag has its enable set.
- R7: A take strobe while `irq_req` is 1 clears the global enable and starts a handler. While the handler runs, `irq_req` stays 0 even if software writes the global enable back to 1, and further take strobes have no effect.
- R8: A return strobe sets the global enable and ends the handler. A flag that is still set with its enable set requests again in the cycle that follows.
- R9: Register 0 bits 3, 4, 5 and 6 are the enables for port change, external pin, timer and nonvolatile event. Bit 7 is the global enable. All eight bits read back as written. In register 1, bits 7 to 1 read 0.
- R10: `vec_addr` always carries the parameter `VEC_ADDR`, which defaults to 0x0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| ext_rise_sel | input | 1 | 1 selects the rising edge of `ext_pin`, 0 the falling edge |
| port_chg | input | 1 | Port-change pulse, synchronous |
| nvm_done | input | 1 | Nonvolatile write complete pulse, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 for the main control register, 1 for the auxiliary flag register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| take_stb | input | 1 | Core accepts the request at an instruction boundary |
| ret_stb | input | 1 | Core executes a return from interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| vec_addr | output | VEC_W | Fixed handler address |

## Verification
The assertions assume that the core never raises `take_stb` and `ret_stb` in the same cycle. They assume that `ret_stb` comes only after a take, and that the three synchronous event inputs are single-cycle pulses aligned to `clk`. The bench drives every strobe for exactly one cycle from the falling clock edge and never overlaps take with return. It changes `ext_pin` only after the synchronizer has settled from the previous change, so every edge it makes is seen exactly once.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int NSRC    = 4;
   localparam int REG_W   = 8;
   localparam int EN_BASE = 3;
   localparam int GIE_BIT = 7;

   typedef enum logic [1:0] {
      SRC_PORT = 2'd0,
      SRC_EXT  = 2'd1,
      SRC_TMR  = 2'd2,
      SRC_NVM  = 2'd3
   } src_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic edge_hit
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_pin_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= pin;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];

   always_comb begin
      if (rise_sel) edge_hit = sync_q[STAGES-1] & ~prev_q;
      else          edge_hit = ~sync_q[STAGES-1] & prev_q;
   end
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_wr,
   input  logic sw_val,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (hw_set) flag <= 1'b1;
      else if (sw_wr)  flag <= sw_val;
   end
endmodule

// File: rtl/irq_svc_ctl.sv
module irq_svc_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic take_ok,
   input  logic ret_stb,
   input  logic sw_wr,
   input  logic sw_gie,
   output logic gie,
   output logic in_svc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie    <= 1'b0;
         in_svc <= 1'b0;
      end else if (ret_stb) begin
         gie    <= 1'b1;
         in_svc <= 1'b0;
      end else if (take_ok) begin
         gie    <= 1'b0;
         in_svc <= 1'b1;
      end else if (sw_wr) begin
         gie    <= sw_gie;
      end
   end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import irq_pkg::*;
#(
   parameter int            VEC_W       = 13,
   parameter logic [12:0]   VEC_ADDR    = 13'h0004,
   parameter int            SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tmr_ovf,
   input  logic               ext_pin,
   input  logic               ext_rise_sel,
   input  logic               port_chg,
   input  logic               nvm_done,
   input  logic               reg_wr,
   input  logic               reg_sel,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic               take_stb,
   input  logic               ret_stb,
   output logic               irq_req,
   output logic [VEC_W-1:0]   vec_addr
);
   if (VEC_W < 3 || VEC_W > 13) begin : g_bad_vec
      $error("irq_vec_ctrl: VEC_W must lie in 3..13");
   end

   logic [NSRC-1:0] set_vec;
   logic [NSRC-1:0] wr_hit;
   logic [NSRC-1:0] wr_val;
   logic [NSRC-1:0] flag_q;
   logic [NSRC-1:0] en_q;
   logic            ext_edge;
   logic            gie;
   logic            in_svc;
   logic            take_ok;
   logic            main_wr;

   irq_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .rise_sel (ext_rise_sel),
      .edge_hit (ext_edge)
   );

   assign main_wr = reg_wr & ~reg_sel;

   always_comb begin
      set_vec[SRC_PORT] = port_chg;
      set_vec[SRC_EXT]  = ext_edge;
      set_vec[SRC_TMR]  = tmr_ovf;
      set_vec[SRC_NVM]  = nvm_done;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_flag
      if (i == int'(SRC_NVM)) begin : g_aux
         assign wr_hit[i] = reg_wr & reg_sel;
         assign wr_val[i] = reg_wdata[0];
      end else begin : g_main
         assign wr_hit[i] = main_wr;
         assign wr_val[i] = reg_wdata[i];
      end
      irq_flag_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .hw_set (set_vec[i]),
         .sw_wr  (wr_hit[i]),
         .sw_val (wr_val[i]),
         .flag   (flag_q[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (main_wr) en_q <= reg_wdata[EN_BASE +: NSRC];
   end

   irq_svc_ctl u_svc (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_ok (take_ok),
      .ret_stb (ret_stb),
      .sw_wr   (main_wr),
      .sw_gie  (reg_wdata[GIE_BIT]),
      .gie     (gie),
      .in_svc  (in_svc)
   );

   assign irq_req  = gie & ~in_svc & (|(flag_q & en_q));
   assign take_ok  = take_stb & irq_req;
   assign vec_addr = VEC_ADDR[VEC_W-1:0];

   always_comb begin
      if (reg_sel) reg_rdata = {{(REG_W-1){1'b0}}, flag_q[SRC_NVM]};
      else         reg_rdata = {gie, en_q, flag_q[SRC_TMR:SRC_PORT]};
   end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
   parameter int          VEC_W    = 13,
   parameter logic [12:0] VEC_ADDR = 13'h0004,
   parameter int          NSRC     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             take_stb,
   input logic             ret_stb,
   input logic             irq_req,
   input logic             gie,
   input logic             in_svc,
   input logic [NSRC-1:0]  flags,
   input logic [NSRC-1:0]  set_vec,
   input logic [NSRC-1:0]  wr_hit,
   input logic [NSRC-1:0]  wr_val,
   input logic [VEC_W-1:0] vec_addr
);
   p_take_clears_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_stb && irq_req && !ret_stb) |=> (!gie && in_svc));

   p_ret_restores_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ret_stb |=> (gie && !in_svc));

   p_req_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!gie || in_svc) |-> !irq_req);

   p_req_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (flags != '0));

   p_vec_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      vec_addr == VEC_ADDR[VEC_W-1:0]);

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[i] |=> flags[i]);
      p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !(wr_hit[i] && !wr_val[i])) |=> flags[i]);
   end
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
   .VEC_W    (VEC_W),
   .VEC_ADDR (VEC_ADDR),
   .NSRC     (irq_pkg::NSRC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .take_stb (take_stb),
   .ret_stb  (ret_stb),
   .irq_req  (irq_req),
   .gie      (gie),
   .in_svc   (in_svc),
   .flags    (flag_q),
   .set_vec  (set_vec),
   .wr_hit   (wr_hit),
   .wr_val   (wr_val),
   .vec_addr (vec_addr)
);

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
   localparam time CLK_PERIOD = 10ns;
   localparam int  VEC_W      = 13;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tmr_ovf = 1'b0, ext_pin = 1'b0, ext_rise_sel = 1'b1;
   logic             port_chg = 1'b0, nvm_done = 1'b0;
   logic             reg_wr = 1'b0, reg_sel = 1'b0;
   logic [7:0]       reg_wdata = '0;
   logic [7:0]       reg_rdata;
   logic             take_stb = 1'b0, ret_stb = 1'b0;
   logic             irq_req;
   logic [VEC_W-1:0] vec_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vec_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
      .ext_rise_sel(ext_rise_sel), .port_chg(port_chg), .nvm_done(nvm_done),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .take_stb(take_stb), .ret_stb(ret_stb),
      .irq_req(irq_req), .vec_addr(vec_addr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic sel, output logic [7:0] val);
      reg_sel = sel;
      #1;
      val = reg_rdata;
   endtask

   task automatic wr(input logic sel, input logic [7:0] data);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0; reg_sel = 1'b0;
   endtask

   // which: 0 port change, 2 timer, 3 nonvolatile
   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: port_chg = 1'b1;
         2: tmr_ovf  = 1'b1;
         default: nvm_done = 1'b1;
      endcase
      @(negedge clk);
      port_chg = 1'b0; tmr_ovf = 1'b0; nvm_done = 1'b0;
   endtask

   task automatic strobe(input bit is_take);
      @(negedge clk);
      if (is_take) take_stb = 1'b1; else ret_stb = 1'b1;
      @(negedge clk);
      take_stb = 1'b0; ret_stb = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(1'b0, v); check("R1 main reg", v, 8'h00);
      rd(1'b1, v); check("R1 aux reg", v, 8'h00);
      check("R1 irq_req", irq_req, 0);
      check("R10 vec_addr", vec_addr, 13'h0004);
   endtask

   task automatic t_events();
      logic [7:0] v;
      pulse(2); rd(1'b0, v); check("R2 timer flag bit2", v, 8'h04);
      check("R6 masked no req", irq_req, 0);
      pulse(0); rd(1'b0, v); check("R2 port flag bit0", v, 8'h05);
      pulse(3); rd(1'b1, v); check("R2 nvm flag aux bit0", v, 8'h01);
      repeat (5) @(negedge clk);
      rd(1'b0, v); check("R4 flags held", v, 8'h05);
      wr(1'b0, 8'h00); rd(1'b0, v); check("R4 main cleared", v, 8'h00);
      rd(1'b1, v); check("R4 aux still set", v, 8'h01);
      wr(1'b1, 8'h00); rd(1'b1, v); check("R4 aux cleared", v, 8'h00);
   endtask

   task automatic t_ext_edge();
      logic [7:0] v;
      ext_rise_sel = 1'b1;
      @(negedge clk); ext_pin = 1'b1;
      repeat (2) @(negedge clk);
      rd(1'b0, v); check("R3 latency not yet", v, 8'h00);
      @(negedge clk);
      rd(1'b0, v); check("R3 rising edge sets", v, 8'h02);
      wr(1'b0, 8'h00);
      @(negedge clk); ext_pin = 1'b0;
      repeat (5) @(negedge clk);
      rd(1'b0, v); check("R3 falling ignored when rise selected", v, 8'h00);
      ext_rise_sel = 1'b0;
      @(negedge clk); ext_pin = 1'b1;
      repeat (5) @(negedge clk);
      rd(1'b0, v); check("R3 rising ignored when fall selected", v, 8'h00);
      @(negedge clk); ext_pin = 1'b0;
      repeat (3) @(negedge clk);
      rd(1'b0, v); check("R3 falling edge sets", v, 8'h02);
      wr(1'b0, 8'h00);
      ext_rise_sel = 1'b1;
   endtask

   task automatic t_set_wins();
      logic [7:0] v;
      pulse(2);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h00; tmr_ovf = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; tmr_ovf = 1'b0;
      rd(1'b0, v); check("R5 set beats clear", v, 8'h04);
      wr(1'b0, 8'h00);
   endtask

   task automatic t_layout();
      logic [7:0] v;
      wr(1'b0, 8'hF8); rd(1'b0, v); check("R9 enables and GIE read back", v, 8'hF8);
      check("R6 no flag no req", irq_req, 0);
      wr(1'b1, 8'hFE); rd(1'b1, v); check("R9 aux upper bits zero", v, 8'h00);
      wr(1'b0, 8'h00);
   endtask

   task automatic t_request();
      logic [7:0] v;
      pulse(2);
      wr(1'b0, 8'h84); check("R6 flag without enable", irq_req, 0);
      wr(1'b0, 8'h24); check("R6 enable without GIE", irq_req, 0);
      wr(1'b0, 8'hA4); check("R6 request raised", irq_req, 1);
      strobe(1'b1);
      check("R7 req drops after take", irq_req, 0);
      rd(1'b0, v); check("R7 GIE cleared flag kept", v, 8'h24);
      wr(1'b0, 8'hA4); check("R7 in handler no req", irq_req, 0);
      strobe(1'b1);
      rd(1'b0, v); check("R7 extra take ignored", v, 8'hA4);
      strobe(1'b0);
      check("R8 pending re-requests", irq_req, 1);
      rd(1'b0, v); check("R8 GIE restored", v, 8'hA4);
      wr(1'b0, 8'hA0); check("R4 cleared no req", irq_req, 0);
      wr(1'b0, 8'hC0); pulse(3);
      check("R6 nvm request", irq_req, 1);
      wr(1'b1, 8'h00); check("R6 nvm cleared", irq_req, 0);
      check("R10 vec_addr stable", vec_addr, 13'h0004);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_events();
      t_ext_edge();
      t_set_wins();
      t_layout();
      t_request();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule